// File: doc/BRIEF.md
# Error Counter Snapshot Controller

This block sits in the host register file of a line-interface framer. It keeps six live error counters fed by one-cycle event strobes from the receive path: framing errors, code violations, errored blocks and three CRC error classes. It also keeps one snapshot of an 8-bit receive buffer delay value. The host works through a byte-wide register bus. It writes a request bit into a write-only control register. On that bit's rising edge, the block freezes the matching counter into a holding register and restarts the live count from zero. The request bit stays set until the host reads the held counter's high byte, or the buffer delay register for the seventh bit. While the bit is set, further requests for that counter are refused.

A mode input hands latching to an automatic mechanism outside this block. While the input is high, host writes to the request bits are ignored. An 8-bit errored-second mask gates a set of per-second error sources into one interrupt output.

Top module: `err_snap_ctrl`

## Requirements
- R1: Each live counter k increments by one on every clock edge where `evt_i[k]` is high. Lane mapping: 0 framing, 1 code violation, 2 errored block, 3/4/5 CRC classes 1/2/3. The held value reads at address 0x08+2k (bits 7:0) and 0x09+2k (bits 15:8).
- R2: A live counter stops at 0xFFFF and does not wrap.
- R3: A write to the control register (address 0x00) is handled per bit k in 0..5. If bit k of the written data is 1, that request bit is currently clear, and `auto_mode_i` is low, the live count is copied into hold k and the live counter is cleared on that same edge. The new held value is readable in the next cycle.
- R4: An event in the same cycle as its counter's latch is counted into the cleared live counter, so it starts at 1.
- R5: A read of address 0x09+2k clears request bit k. A read of address 0x08+2k leaves the bit unchanged.
- R6: Writing 0 to a request bit has no effect. Writing 1 to a request bit that is already set has no effect: no new latch and no clear.
- R7: Control bit 6 latches `bufdly_i` into the buffer delay hold, which reads at address 0x02, using the same rising-edge rule. A read of address 0x02 clears bit 6.
- R8: While `auto_mode_i` is high, writes to the control register change no request bit, no held value and no live count.
- R9: After reset, all request bits are clear, every held value and live count is 0, and the mask is 0xFF. The control register reads as 0x00.
- R10: The mask at address 0x01 is read/write. `es_irq_o` is high when any bit of `es_src_i` is 1 at a position where the mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_mode_i | input | 1 | High: automatic latching, host requests ignored |
| evt_i | input | 6 | Per-counter error event strobes |
| bufdly_i | input | 8 | Live receive buffer delay value |
| es_src_i | input | 8 | Errored-second sources |
| es_irq_o | output | 1 | Unmasked errored-second interrupt |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational from address) |

## Verification
Read data and the interrupt are combinational, so they are due in the same cycle the address or source is applied. A latch caused by a control write is visible on `rdata_o` from the cycle after the write edge. A clear-on-read takes effect at the edge that ends the read cycle. The bench drives inputs just after the falling edge and samples a quarter period later, before the next rising edge. A behavioural model updated on each rising edge is compared with `rdata_o` and `es_irq_o` at every falling edge, and directed checks with fixed expected values cover each requirement.

// File: rtl/err_snap_pkg.sv
package err_snap_pkg;
  localparam int unsigned NUM_CNT  = 6;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned AW       = 5;
  localparam int unsigned DW       = 8;
  localparam int unsigned ES_W     = 8;
  localparam int unsigned REQ_W    = NUM_CNT + 1;
  localparam int unsigned BDLY_BIT = NUM_CNT;

  localparam logic [AW-1:0] ADDR_CTRL = 5'h00;
  localparam logic [AW-1:0] ADDR_MASK = 5'h01;
  localparam logic [AW-1:0] ADDR_BDLY = 5'h02;
  localparam logic [AW-1:0] ADDR_CNT0 = 5'h08;

  function automatic logic [AW-1:0] cnt_lo_addr(input int unsigned k);
    return ADDR_CNT0 + AW'(2 * k);
  endfunction

  function automatic logic [AW-1:0] cnt_hi_addr(input int unsigned k);
    return ADDR_CNT0 + AW'(2 * k + 1);
  endfunction
endpackage

// File: rtl/err_cnt_lane.sv
module err_cnt_lane #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] live_q, live_d;
  logic [CNT_W-1:0] hold_q;

  always_comb begin
    live_d = live_q;
    if (latch_i)
      live_d = evt_i ? CNT_W'(1) : '0;  // event on latch edge is kept
    else if (evt_i && live_q != CNT_MAX)
      live_d = live_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= live_d;
      if (latch_i) hold_q <= live_q;
    end
  end

  assign live_o = live_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/err_req_ctrl.sv
module err_req_ctrl
  import err_snap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_mode_i,
  input  logic             wr_ctrl_i,
  input  logic [REQ_W-1:0] wdata_i,
  input  logic [REQ_W-1:0] rd_clr_i,
  output logic [REQ_W-1:0] req_o,
  output logic [REQ_W-1:0] latch_o
);
  logic [REQ_W-1:0] req_q, req_d, set_w;

  // only a 0->1 transition of a request bit latches
  assign set_w   = (wr_ctrl_i && !auto_mode_i) ? (wdata_i & ~req_q) : '0;
  assign req_d   = (req_q & ~rd_clr_i) | set_w;
  assign latch_o = set_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/err_rd_mux.sv
module err_rd_mux
  import err_snap_pkg::*;
(
  input  logic [AW-1:0]                   addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   hold_i,
  input  logic [DW-1:0]                   bdly_i,
  input  logic [ES_W-1:0]                 mask_i,
  output logic [DW-1:0]                   rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o = '0;  // write-only
      ADDR_MASK: rdata_o = DW'(mask_i);
      ADDR_BDLY: rdata_o = bdly_i;
      default: begin
        for (int unsigned k = 0; k < NUM_CNT; k++) begin
          if (addr_i == cnt_lo_addr(k)) rdata_o = hold_i[k][0 +: DW];
          if (addr_i == cnt_hi_addr(k)) rdata_o = hold_i[k][DW +: DW];
        end
      end
    endcase
  end
endmodule

// File: rtl/err_snap_ctrl.sv
module err_snap_ctrl
  import err_snap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_mode_i,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic [DW-1:0]      bufdly_i,
  input  logic [ES_W-1:0]    es_src_i,
  output logic               es_irq_o,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DW-1:0]      rdata_o
);
  logic                         wr_ctrl, wr_mask;
  logic [REQ_W-1:0]             rd_clr, req_q, latch;
  logic [NUM_CNT-1:0][CNT_W-1:0] live_cnt, hold_cnt;
  logic [DW-1:0]                bdly_q;
  logic [ES_W-1:0]              mask_q;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_mask = we_i && (addr_i == ADDR_MASK);

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_clr
      assign rd_clr[k] = re_i && (addr_i == cnt_hi_addr(k));
    end
  endgenerate
  assign rd_clr[BDLY_BIT] = re_i && (addr_i == ADDR_BDLY);

  err_req_ctrl u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_mode_i(auto_mode_i),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (wdata_i[REQ_W-1:0]),
    .rd_clr_i   (rd_clr),
    .req_o      (req_q),
    .latch_o    (latch)
  );

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_lane
      err_cnt_lane #(.CNT_W(CNT_W)) u_lane (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i[k]),
        .latch_i(latch[k]),
        .live_o (live_cnt[k]),
        .hold_o (hold_cnt[k])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bdly_q <= '0;
      mask_q <= '1;
    end else begin
      if (latch[BDLY_BIT]) bdly_q <= bufdly_i;
      if (wr_mask)         mask_q <= wdata_i[ES_W-1:0];
    end
  end

  assign es_irq_o = |(es_src_i & ~mask_q);

  err_rd_mux u_mux (
    .addr_i (addr_i),
    .hold_i (hold_cnt),
    .bdly_i (bdly_q),
    .mask_i (mask_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/err_snap_chk.sv
module err_snap_chk
  import err_snap_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          auto_mode_i,
  input logic                          we_i,
  input logic                          re_i,
  input logic [AW-1:0]                 addr_i,
  input logic [REQ_W-1:0]              req_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] live_cnt,
  input logic [NUM_CNT-1:0][CNT_W-1:0] hold_cnt,
  input logic [ES_W-1:0]               mask_q,
  input logic                          es_irq_o
);
  // R8
  auto_mode_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL && auto_mode_i && !re_i) |=> $stable(req_q));

  // R10
  full_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == {ES_W{1'b1}}) |-> !es_irq_o);

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_lane_chk
      // R3
      snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_q[k]) |-> (hold_cnt[k] == $past(live_cnt[k])));

      // R3
      hold_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$rose(req_q[k]) |-> $stable(hold_cnt[k]));

      // R2
      no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_cnt[k] == {CNT_W{1'b1}}) |=>
          (live_cnt[k] == {CNT_W{1'b1}} || live_cnt[k] <= CNT_W'(1)));

      // R5
      hi_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && !we_i && addr_i == cnt_hi_addr(k)) |=> !req_q[k]);

      // R6
      req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q[k] && !(re_i && addr_i == cnt_hi_addr(k))) |=> req_q[k]);
    end
  endgenerate
endmodule

bind err_snap_ctrl err_snap_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .auto_mode_i(auto_mode_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .addr_i     (addr_i),
  .req_q      (req_q),
  .live_cnt   (live_cnt),
  .hold_cnt   (hold_cnt),
  .mask_q     (mask_q),
  .es_irq_o   (es_irq_o)
);

// File: tb/tb_err_snap_ctrl.sv
module tb_err_snap_ctrl;
  localparam int CLK_P = 10;
  localparam int MAXC  = 65535;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_mode = 1'b0;
  logic [5:0] evt = '0;
  logic [7:0] bufdly = '0;
  logic [7:0] es_src = '0;
  logic       es_irq;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  err_snap_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .auto_mode_i(auto_mode), .evt_i(evt),
    .bufdly_i(bufdly), .es_src_i(es_src), .es_irq_o(es_irq),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata)
  );

  // behavioural reference
  int m_live[6];
  int m_hold[6];
  bit m_req[7];
  int m_bd;
  int m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) begin m_live[k] = 0; m_hold[k] = 0; end
      for (int k = 0; k < 7; k++) m_req[k] = 0;
      m_bd = 0;
      m_mask = 255;
    end else begin
      bit setb[7];
      bit clrb[7];
      for (int k = 0; k < 7; k++) begin
        setb[k] = we && addr == 5'h00 && !auto_mode && wdata[k] && !m_req[k];
        clrb[k] = 0;
      end
      for (int k = 0; k < 6; k++) clrb[k] = re && (int'(addr) == 9 + 2*k);
      clrb[6] = re && addr == 5'h02;
      for (int k = 0; k < 6; k++) begin
        if (setb[k]) begin
          m_hold[k] = m_live[k];
          m_live[k] = evt[k] ? 1 : 0;
        end else if (evt[k] && m_live[k] < MAXC) begin
          m_live[k] = m_live[k] + 1;
        end
      end
      if (setb[6]) m_bd = int'(bufdly);
      if (we && addr == 5'h01) m_mask = int'(wdata);
      for (int k = 0; k < 7; k++) m_req[k] = (m_req[k] && !clrb[k]) || setb[k];
    end
  end

  function automatic int exp_rd(input logic [4:0] a);
    int r;
    r = 0;
    if (a == 5'h01) r = m_mask;
    else if (a == 5'h02) r = m_bd;
    else
      for (int k = 0; k < 6; k++) begin
        if (int'(a) == 8 + 2*k) r = m_hold[k] & 255;
        if (int'(a) == 9 + 2*k) r = (m_hold[k] >> 8) & 255;
      end
    return r;
  endfunction

  // per-cycle model comparison (R1 R3 R10)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(rdata) != exp_rd(addr)) begin
        errors++;
        $display("FAIL model R1 rdata addr=%0h actual=%0h expected=%0h", addr, rdata, exp_rd(addr));
      end
      checks++;
      if (es_irq != |(es_src & ~8'(m_mask))) begin
        errors++;
        $display("FAIL model R10 irq actual=%0b expected=%0b", es_irq, |(es_src & ~8'(m_mask)));
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [5:0] e = '0);
    @(negedge clk); #1;
    addr = a; wdata = d; we = 1'b1; evt = e;
    @(negedge clk); #1;
    we = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk); #1;
    addr = a; re = 1'b1;
    #(CLK_P/4);
    v = int'(rdata);
    @(negedge clk); #1;
    re = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m, input int n);
    @(negedge clk); #1;
    evt = m;
    repeat (n) @(negedge clk);
    #1 evt = '0;
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    rd(5'h00, v); check("R9 ctrl reads zero", v, 8'h00);
    rd(5'h01, v); check("R9 mask reset", v, 8'hFF);
    rd(5'h08, v); check("R9 hold reset", v, 0);
    es_src = 8'hFF; #(CLK_P/4);
    check("R10 full mask blocks irq", int'(es_irq), 0);
    es_src = '0;

    // R1 R3 two lanes latched together
    pulse(6'b000011, 3);
    pulse(6'b000001, 2);
    wr(5'h00, 8'h03);
    rd(5'h08, v); check("R1 lane0 count", v, 5);
    rd(5'h09, v); check("R3 lane0 high byte", v, 0);
    rd(5'h0A, v); check("R1 lane1 count", v, 3);

    // R3 R4 live clear and same-cycle event
    pulse(6'b000001, 4);
    wr(5'h00, 8'h01, 6'b000001);
    rd(5'h08, v); check("R3 lane0 relatch", v, 4);
    rd(5'h09, v);
    pulse(6'b000001, 2);
    wr(5'h00, 8'h01);
    rd(5'h08, v); check("R4 event at latch kept", v, 3);

    // R5 R6 lane1 bit still set after low-byte read only
    pulse(6'b000010, 4);
    wr(5'h00, 8'h02);
    rd(5'h0A, v); check("R5 low read keeps bit", v, 3);
    wr(5'h00, 8'h00);
    wr(5'h00, 8'h02);
    rd(5'h0A, v); check("R6 zero write no effect", v, 3);
    rd(5'h0B, v);
    wr(5'h00, 8'h02);
    rd(5'h0A, v); check("R5 high read clears bit", v, 4);

    // R8 automatic mode ignores requests
    pulse(6'b000100, 7);
    auto_mode = 1'b1;
    wr(5'h00, 8'h04);
    rd(5'h0C, v); check("R8 write ignored", v, 0);
    auto_mode = 1'b0;
    wr(5'h00, 8'h04);
    rd(5'h0C, v); check("R8 live kept", v, 7);

    // R7 buffer delay snapshot
    bufdly = 8'h5A;
    wr(5'h00, 8'h40);
    bufdly = 8'h33;
    wr(5'h00, 8'h40);
    rd(5'h02, v); check("R7 no relatch while set", v, 8'h5A);
    wr(5'h00, 8'h40);
    rd(5'h02, v); check("R7 relatch after read", v, 8'h33);

    // R10 mask
    wr(5'h01, 8'hFE);
    rd(5'h01, v); check("R10 mask readback", v, 8'hFE);
    es_src = 8'h01; #(CLK_P/4);
    check("R10 unmasked source", int'(es_irq), 1);
    es_src = 8'h02; #(CLK_P/4);
    check("R10 masked source", int'(es_irq), 0);
    es_src = '0;

    // R1 CRC lanes
    pulse(6'b011000, 2);
    wr(5'h00, 8'h18);
    rd(5'h0E, v); check("R1 crc1 count", v, 2);
    rd(5'h10, v); check("R1 crc2 count", v, 2);

    // R2 saturation on crc3
    pulse(6'b100000, 66000);
    wr(5'h00, 8'h20);
    rd(5'h12, v); check("R2 saturated low", v, 8'hFF);
    rd(5'h13, v); check("R2 saturated high", v, 8'hFF);
    wr(5'h00, 8'h20);
    rd(5'h12, v); check("R3 live cleared after latch", v, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule